// File: doc/BRIEF.md
# Programmable Interval Counter Bank

A bank of three independent 16-bit down-counters that share one count-clock enable (`tick_i`), which pulses at a 1.193182 MHz rate. A byte-wide bus reaches the bank through four addresses: one data address for each counter and one control-word address. Software programs a counter in three steps. It writes a control word that picks the counter, the byte-access order and the mode. It then writes the reload value, one or two bytes. Counting starts on the next count-clock pulse. A counter can run as a rate generator, which gives a one-tick low pulse every N ticks. It can also run as a square-wave generator, which steps the count down by two per tick.

A latch command takes a snapshot of a running count. The two bytes of the snapshot can then be read one after the other and stay consistent while the counter keeps going. Counters 0 and 1 take their gate from pins. Counter 2 takes its gate from bit 0 of a small system control register. Bit 1 of that register enables the speaker output, which is the AND of this bit and counter 2's output.

Top module: `interval_timer_bank`

## Requirements
- R1: After reset every counter output is high, the speaker output is low and a read of a counter returns 0x00.
- R2: Control word fields: bits 7:6 pick the counter (0..2, where 3 selects nothing and is ignored); bits 5:4 pick access (00 latch, 01 low byte only, 10 high byte only, 11 low then high); bits 3:1 pick the mode, where low bits 11 select square wave and any other value selects rate generator; bit 0 (BCD) is ignored and counting is always binary. A non-latch control word stops its counter and drives its output high.
- R3: With access 11 the first data write is the low byte and the second is the high byte. Low-only access clears the high byte and high-only access clears the low byte. A completed reload is loaded on the first tick that follows with the gate high.
- R4: Rate generator with reload N: the count falls by one per tick, the output is low for exactly one tick while the count is 1, and then the count reloads, so the period is N ticks.
- R5: Square wave with reload N ≥ 2: the output toggles at each reload. It stays high for (N+1)/2 ticks and low for N/2 ticks (integer division), so both halves are equal for even N.
- R6: A latch command freezes the count. The next two reads return the frozen low byte and then the frozen high byte while counting goes on. Further latch commands are ignored until both bytes have been read.
- R7: Without a pending snapshot, reads return the live count in the programmed access order; access 11 alternates the low byte and the high byte.
- R8: A reload written while a counter runs does not disturb the current cycle and takes effect at the next reload point.
- R9: A low gate pauses counting and forces the output high. A rising gate restarts the counter from its reload value on the next tick.
- R10: System register bit 0 is counter 2's gate and bit 1 is the speaker enable. The speaker output is counter 2's output ANDed with the enable, so clearing both bits silences it.
- R11: Counts and outputs change only on ticks, bus writes or gate changes; without ticks the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable, one pulse per count period |
| addr_i | input | 2 | Bus address: 0..2 counter data, 3 control word |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe; advances the read byte order |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data for the addressed counter |
| gate_i | input | 2 | Gates of counters 0 and 1 |
| sys_wr_i | input | 1 | Write strobe of the system control register |
| sys_wdata_i | input | 2 | System register data: bit 0 counter 2 gate, bit 1 speaker enable |
| out_o | output | 3 | Counter outputs |
| spk_o | output | 1 | Speaker output |

## Verification
The assertions assume that the bus never strobes a read and a write in the same cycle, and that a tick never coincides with a bus write or with a gate edge. The rule that outputs move only after a tick, a write or a gate change relies on this separation. The stimulus keeps to these rules: every bus access, tick pulse and gate change is driven in its own clock slot. Square-wave reloads are kept at 2 or more, because 0 and 1 have no defined half-period here.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } cw_t;
endpackage

// File: rtl/itb_loader.sv
module itb_loader import ictr_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_i,
  input  acc_e                acc_i,
  input  logic                wr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output acc_e                acc_o,
  output logic [2*BYTE_W-1:0] reload_o,
  output logic                load_o
);
  acc_e              acc_q;
  logic              hi_next_q;
  logic [BYTE_W-1:0] lo_q;
  logic [2*BYTE_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_LOHI;
      hi_next_q <= 1'b0;
      lo_q      <= '0;
      reload_q  <= '0;
    end else if (prog_i) begin
      acc_q     <= acc_i;
      hi_next_q <= 1'b0;
    end else if (wr_i) begin
      unique case (acc_q)
        ACC_LO: reload_q <= {{BYTE_W{1'b0}}, wdata_i};
        ACC_HI: reload_q <= {wdata_i, {BYTE_W{1'b0}}};
        default: begin
          if (!hi_next_q) begin
            lo_q      <= wdata_i;
            hi_next_q <= 1'b1;
          end else begin
            reload_q  <= {wdata_i, lo_q};
            hi_next_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // completion pulse: single-byte modes, or second byte of a pair
  assign load_o   = wr_i && !prog_i && (acc_q != ACC_LOHI || hi_next_q);
  assign acc_o    = acc_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/itb_counter.sv
module itb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             prog_i,
  input  logic             sq_mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic             sq_q, armed_q, pend_q, run_q, out_q, gate_q;
  logic [CNT_W-1:0] cnt_q, step;
  logic             gate_rise, at_end;

  assign gate_rise = gate_i & ~gate_q;

  // odd square-wave reload: step 1 first in the high half, 3 in the low half
  always_comb begin
    if (!sq_q)          step = CNT_W'(1);
    else if (!cnt_q[0]) step = CNT_W'(2);
    else if (out_q)     step = CNT_W'(1);
    else                step = CNT_W'(3);
  end

  assign at_end = sq_q ? (cnt_q <= step) : (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      sq_q    <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      gate_q <= gate_i;
      if (prog_i) begin
        sq_q    <= sq_mode_i;
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
        run_q   <= 1'b0;
        out_q   <= 1'b1;
      end else begin
        if (load_i) begin
          armed_q <= 1'b1;
          if (!run_q) pend_q <= 1'b1;
        end
        if (gate_rise && (armed_q || load_i)) begin
          pend_q <= 1'b1;
          run_q  <= 1'b0;
        end
        if (!gate_i) begin
          out_q <= 1'b1;
        end else if (tick_i) begin
          if (pend_q) begin
            cnt_q  <= reload_i;
            run_q  <= 1'b1;
            pend_q <= 1'b0;
            out_q  <= 1'b1;
          end else if (run_q) begin
            if (at_end) begin
              cnt_q <= reload_i;
              if (sq_q) out_q <= ~out_q;
            end else begin
              cnt_q <= cnt_q - step;
            end
          end
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign out_o   = sq_q ? (out_q | ~gate_i)
                        : ~(run_q & gate_i & (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/itb_readout.sv
module itb_readout import ictr_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_i,
  input  logic                latch_i,
  input  logic                rd_i,
  input  acc_e                acc_i,
  input  logic [2*BYTE_W-1:0] count_i,
  output logic [BYTE_W-1:0]   rdata_o
);
  logic [2*BYTE_W-1:0] snap_q;
  logic                snap_vld_q, snap_hi_q, live_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
      snap_hi_q  <= 1'b0;
      live_hi_q  <= 1'b0;
    end else if (prog_i) begin
      snap_vld_q <= 1'b0;
      snap_hi_q  <= 1'b0;
      live_hi_q  <= 1'b0;
    end else begin
      if (latch_i && !snap_vld_q) begin
        snap_q     <= count_i;
        snap_vld_q <= 1'b1;
        snap_hi_q  <= 1'b0;
      end
      if (rd_i) begin
        if (snap_vld_q) begin
          if (snap_hi_q) begin
            snap_vld_q <= 1'b0;
            snap_hi_q  <= 1'b0;
          end else begin
            snap_hi_q <= 1'b1;
          end
        end else if (acc_i == ACC_LOHI) begin
          live_hi_q <= ~live_hi_q;
        end
      end
    end
  end

  always_comb begin
    if (snap_vld_q) begin
      rdata_o = snap_hi_q ? snap_q[2*BYTE_W-1:BYTE_W] : snap_q[BYTE_W-1:0];
    end else begin
      unique case (acc_i)
        ACC_HI:   rdata_o = count_i[2*BYTE_W-1:BYTE_W];
        ACC_LOHI: rdata_o = live_hi_q ? count_i[2*BYTE_W-1:BYTE_W] : count_i[BYTE_W-1:0];
        default:  rdata_o = count_i[BYTE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank import ictr_pkg::*; #(
  parameter int N_CH   = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [N_CH-2:0]   gate_i,
  input  logic              sys_wr_i,
  input  logic [1:0]        sys_wdata_i,
  output logic [N_CH-1:0]   out_o,
  output logic              spk_o
);
  localparam int          CNT_W     = 2 * BYTE_W;
  localparam logic [1:0]  CTRL_ADDR = 2'd3;
  localparam int          SYS_GATE  = 0;
  localparam int          SYS_SPK   = 1;

  logic [1:0]        sys_q;
  cw_t               cw;
  logic              cw_hit;
  logic              cw_unused;
  logic [BYTE_W-1:0] ch_rd [N_CH];

  assign cw        = cw_t'(wdata_i[7:0]);
  assign cw_hit    = wr_i && (addr_i == CTRL_ADDR);
  assign cw_unused = ^{cw.mode[2], cw.bcd};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sys_q <= '0;
    else if (sys_wr_i) sys_q <= sys_wdata_i;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic             sel_hit, prog, latch, dwr, drd, gate, load;
    acc_e             acc;
    logic [CNT_W-1:0] reload, count;

    assign sel_hit = cw_hit && (cw.sel == 2'(ch));
    assign prog    = sel_hit && (cw.acc != ACC_LATCH);
    assign latch   = sel_hit && (cw.acc == ACC_LATCH);
    assign dwr     = wr_i && (addr_i == 2'(ch));
    assign drd     = rd_i && (addr_i == 2'(ch));

    if (ch == N_CH - 1) begin : g_sysgate
      assign gate = sys_q[SYS_GATE];
    end else begin : g_pingate
      assign gate = gate_i[ch];
    end

    itb_loader #(.BYTE_W(BYTE_W)) u_load (
      .clk_i, .rst_ni, .prog_i(prog), .acc_i(cw.acc), .wr_i(dwr),
      .wdata_i, .acc_o(acc), .reload_o(reload), .load_o(load)
    );

    itb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .tick_i, .gate_i(gate), .prog_i(prog),
      .sq_mode_i(cw.mode[1:0] == 2'b11), .load_i(load), .reload_i(reload),
      .count_o(count), .out_o(out_o[ch])
    );

    itb_readout #(.BYTE_W(BYTE_W)) u_rd (
      .clk_i, .rst_ni, .prog_i(prog), .latch_i(latch), .rd_i(drd),
      .acc_i(acc), .count_i(count), .rdata_o(ch_rd[ch])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++)
      if (addr_i == 2'(i)) rdata_o = ch_rd[i];
  end

  assign spk_o = out_o[N_CH-1] & sys_q[SYS_SPK];
endmodule

// File: rtl/itb_chk.sv
module itb_chk #(
  parameter int N_CH = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic [1:0]      addr_i,
  input logic            wr_i,
  input logic [3:0]      cw_hi_i,
  input logic [N_CH-2:0] gate_i,
  input logic [N_CH-1:0] out_o,
  input logic            spk_o,
  input logic [1:0]      sys_q
);
  AST_SPK_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_q[1] |-> !spk_o); // R10

  AST_GATE_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i[0] |-> out_o[0]); // R9

  AST_OUT_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && !$past(wr_i) && $stable(gate_i) && $past($stable(gate_i)))
      |-> $stable(out_o[N_CH-2:0])); // R11

  AST_PROG_RAISES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && addr_i == 2'd3 && cw_hi_i[3:2] == 2'd0 && cw_hi_i[1:0] != 2'd0)
      |-> out_o[0]); // R2
endmodule

bind interval_timer_bank itb_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i), .wr_i(wr_i),
  .cw_hi_i(wdata_i[7:4]), .gate_i(gate_i), .out_o(out_o), .spk_o(spk_o), .sys_q(sys_q)
);

// File: tb/interval_timer_bank_test.sv
module interval_timer_bank_test;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] gate = 2'b11;
  logic       sys_wr = 1'b0;
  logic [1:0] sys_wdata = '0;
  logic [2:0] out;
  logic       spk;

  typedef struct { int sel; int exp; string tag; } item_t;
  item_t q[$];
  logic  mon_req = 1'b0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  always #2 clk = ~clk;

  interval_timer_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .gate_i(gate), .sys_wr_i(sys_wr),
    .sys_wdata_i(sys_wdata), .out_o(out), .spk_o(spk)
  );

  // monitor: sel 0 rdata, 1..3 out bit, 4 speaker, 5 out vector
  always @(negedge clk) begin
    item_t it;
    int    act;
    if (mon_req) begin
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: no expected item queued");
      end else begin
        it = q.pop_front();
        case (it.sel)
          0: act = int'(rdata);
          1: act = int'(out[0]);
          2: act = int'(out[1]);
          3: act = int'(out[2]);
          4: act = int'(spk);
          default: act = int'(out);
        endcase
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input int exp, input string tag);
    @(posedge clk); #1; addr = a; rd = 1'b1;
    q.push_back('{0, exp, tag}); mon_req = 1'b1;
    @(posedge clk); #1; rd = 1'b0; mon_req = 1'b0;
  endtask

  task automatic expect_sig(input int sel, input int exp, input string tag);
    @(posedge clk); #1;
    q.push_back('{sel, exp, tag}); mon_req = 1'b1;
    @(posedge clk); #1; mon_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
    end
  endtask

  task automatic sys_set(input logic [1:0] v);
    @(posedge clk); #1; sys_wdata = v; sys_wr = 1'b1;
    @(posedge clk); #1; sys_wr = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_sig(5, 7, "R1 outputs high");
    expect_sig(4, 0, "R1 speaker low");
    bus_rd(0, 0, "R1 count reads zero");

    // R4 rate generator, ch0 reload 4
    bus_wr(3, 8'h34); bus_wr(0, 8'h04); bus_wr(0, 8'h00);
    ticks(1);
    for (int t = 0; t < 8; t++) begin
      if (t > 0) ticks(1);
      expect_sig(1, ((4 - (t % 4)) == 1) ? 0 : 1, "R4 rate output");
    end
    ticks(1);

    // R8 reload 3 written mid-cycle
    bus_wr(0, 8'h03); bus_wr(0, 8'h00);
    ticks(3);
    expect_sig(1, 0, "R8 old cycle completes");
    ticks(1);
    bus_rd(0, 3, "R8 new reload low byte");
    bus_rd(0, 0, "R8 new reload high byte");
    ticks(2);
    expect_sig(1, 0, "R8 new period of 3");

    // R9 gate
    gate = 2'b10;
    expect_sig(1, 1, "R9 gate low forces high");
    ticks(3);
    bus_rd(0, 1, "R9 count held low byte");
    bus_rd(0, 0, "R9 count held high byte");
    gate = 2'b11;
    ticks(1);
    bus_rd(0, 3, "R9 restart from reload");
    bus_rd(0, 0, "R9 restart high byte");
    ticks(1);
    bus_rd(0, 2, "R9 counting resumes");
    bus_rd(0, 0, "R9 resume high byte");

    // R11 no tick, no count
    repeat (20) @(posedge clk);
    bus_rd(0, 2, "R11 count holds without tick");
    bus_rd(0, 0, "R11 high byte holds");

    // R3 single-byte access orders
    bus_wr(3, 8'h14); bus_wr(0, 8'h05);
    ticks(1);
    bus_rd(0, 5, "R3 low-only load");
    ticks(1);
    bus_rd(0, 4, "R3 low-only decrement");
    bus_wr(3, 8'h24); bus_wr(0, 8'h02);
    ticks(1);
    bus_rd(0, 2, "R3 high-only load");
    ticks(1);
    bus_rd(0, 1, "R3 high byte after decrement");

    // R2 reprogram stops counter
    bus_wr(3, 8'h34);
    expect_sig(1, 1, "R2 control word raises output");
    ticks(3);
    bus_rd(0, 8'hFF, "R2 stopped low byte");
    bus_rd(0, 8'h01, "R2 stopped high byte");

    // R6 latch on ch1
    bus_wr(3, 8'h74); bus_wr(1, 8'h34); bus_wr(1, 8'h12);
    ticks(6);
    bus_wr(3, 8'h40);
    ticks(3);
    bus_wr(3, 8'h40);
    bus_rd(1, 8'h2F, "R6 latched low byte");
    ticks(2);
    bus_rd(1, 8'h12, "R6 latched high byte");
    // R7 live reads
    bus_rd(1, 8'h2A, "R7 live low byte");
    bus_rd(1, 8'h12, "R7 live high byte");
    bus_wr(3, 8'h40);
    ticks(1);
    bus_rd(1, 8'h2A, "R6 relatch low byte");
    bus_rd(1, 8'h12, "R6 relatch high byte");

    // R2 BCD bit ignored, select 3 ignored
    bus_wr(3, 8'h75); bus_wr(1, 8'h10); bus_wr(1, 8'h00);
    ticks(2);
    bus_rd(1, 8'h0F, "R2 binary count despite BCD bit");
    bus_rd(1, 8'h00, "R2 BCD high byte");
    bus_wr(3, 8'hF4);
    ticks(1);
    bus_rd(1, 8'h0E, "R2 select 3 ignored");
    bus_rd(1, 8'h00, "R2 select 3 high byte");

    // R5 / R10 square wave on ch2
    bus_wr(3, 8'hB6); bus_wr(2, 8'h04); bus_wr(2, 8'h00);
    ticks(2);
    expect_sig(3, 1, "R10 gate bit clear holds out2 high");
    expect_sig(4, 0, "R10 speaker off");
    sys_set(2'b11);
    ticks(1);
    for (int t = 0; t < 8; t++) begin
      if (t > 0) ticks(1);
      expect_sig(3, ((t % 4) < 2) ? 1 : 0, "R5 square even reload");
      expect_sig(4, ((t % 4) < 2) ? 1 : 0, "R10 speaker follows out2");
    end
    bus_wr(2, 8'h05); bus_wr(2, 8'h00);
    for (int t = 0; t < 10; t++) begin
      ticks(1);
      expect_sig(3, ((t % 5) < 3) ? 1 : 0, "R5 square odd reload");
    end
    sys_set(2'b01);
    expect_sig(4, 0, "R10 speaker disabled");
    sys_set(2'b00);
    expect_sig(4, 0, "R10 both bits clear silent");
    expect_sig(3, 1, "R10 gate clear out2 high");

    done = 1;
    summary();
    $finish;
  end
endmodule